// File: doc/BRIEF.md
# Execute-Permission Checker with Translation Cache

This block sits behind address translation and decides, for each access, whether it may go ahead. A small fully associative translation cache keeps the attribute bits of recently used page entries. Each request carries a virtual page number, an access kind (read, write or instruction fetch) and the current privilege. The block looks the page up in the cache and answers one cycle later with exactly one of three pulses: grant, fault or miss. A fault comes with an error code. The code separates a missing page from a protection violation, and it flags whether the access was a fetch, a write or came from user mode.

The no-execute attribute only blocks instruction fetches, and only while the global no-execute enable input is high. Reads and writes to a no-execute page follow the page's other permissions. The rule is the same at every privilege level. A large page is matched on its upper page-number bits only, so a single attribute set, no-execute included, covers the whole page. On a miss the block raises a miss pulse instead of a fault. Refill is done from outside through the fill port, which writes entries in round-robin order. A flush input empties the cache.

Top module: `ifetch_perm_check`

## Requirements
- R1: After reset, grant, fault, miss and fault_code are all 0 and the cache holds no valid entry, so the first request misses.
- R2: A request whose page number matches no valid entry produces miss=1 with grant=0, fault=0 and fault_code=0.
- R3: Fills go into entries 0,1,...,ENTRIES-1 in turn and then wrap, so the ninth distinct fill after a flush evicts the first one.
- R4: Flush clears every valid bit and returns the fill pointer to entry 0. A fill in the same cycle as a flush is dropped.
- R5: Each request gets its response in the cycle after it is presented, and that response is exactly one of grant, fault or miss. There is no response without a request.
- R6: A hit on an entry whose present bit (page entry bit 0) is 0 faults with error code bit 0 = 0.
- R7: With nx_enable=1, a fetch (req_type 2'b10) that hits an entry with the no-execute bit (page entry bit 63) set faults with error code bits 0 and 4 both 1.
- R8: With nx_enable=0, the no-execute bit is ignored and a fetch from a present, otherwise permitted page is granted.
- R9: A read (2'b00, and 2'b11 counts as a read) or write (2'b01) to a no-execute page is granted when the writable (bit 1) and user (bit 2) permissions allow it.
- R10: The no-execute check is the same for user (req_user=1) and supervisor requests. A write to a page with bit 1 = 0 faults, and so does a user access to a page with bit 2 = 0.
- R11: Error code layout: bit 0 = page present, bit 1 = write access, bit 2 = user access, bit 3 = 0, bit 4 = instruction fetch. The code is 0 in every cycle without a fault.
- R12: An entry filled with page entry bit 7 set is a large page. It matches any request whose page number agrees above the low LARGE_BITS bits, and its single no-execute bit applies across the whole range.
- R13: A lookup in the same cycle as a fill or flush sees the cache contents from before that update. When several entries match, the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cache entries |
| fill_valid | input | 1 | Write one entry at the round-robin pointer |
| fill_vpn | input | VPN_W | Page number tag of the entry being written |
| fill_pte | input | 64 | Page entry: bit 0 present, 1 writable, 2 user, 7 large, 63 no-execute |
| req_valid | input | 1 | Access request present |
| req_type | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| req_vpn | input | VPN_W | Page number of the access |
| req_user | input | 1 | 1 = user-mode access |
| nx_enable | input | 1 | Global no-execute enforcement enable |
| grant | output | 1 | Access allowed (one-cycle pulse) |
| fault | output | 1 | Access refused (one-cycle pulse) |
| miss | output | 1 | No cached translation (one-cycle pulse) |
| fault_code | output | 5 | Error code valid with fault, else 0 |

## Verification
The bench targets fetches to no-execute pages with the enable switched both ways, in user and supervisor mode. A design that gates the attribute wrongly would either let injected code run or refuse legitimate fetches. It checks that data accesses to such pages still go through, since a check that ignores the access kind faults on ordinary loads and stores. It also probes the error code bits for not-present, write and user faults, large-page matching across the low page bits, wrap-around of the round-robin pointer, and a flush that collides with a fill. Mistakes there show up as a wrong code bit, a stale hit after flush, or the wrong entry being evicted.

// File: rtl/ifetch_perm_check.sv
module ifetch_perm_check #(
  parameter int VPN_W      = 20,
  parameter int ENTRIES    = 8,
  parameter int LARGE_BITS = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [63:0]      fill_pte,
  input  logic             req_valid,
  input  logic [1:0]       req_type,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic             req_user,
  input  logic             nx_enable,
  output logic             grant,
  output logic             fault,
  output logic             miss,
  output logic [4:0]       fault_code
);
  localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int BIT_P  = 0;
  localparam int BIT_W  = 1;
  localparam int BIT_U  = 2;
  localparam int BIT_LG = 7;
  localparam int BIT_NX = 63;
  localparam logic [1:0] ACC_WRITE = 2'b01;
  localparam logic [1:0] ACC_FETCH = 2'b10;

  logic [ENTRIES-1:0] e_valid, e_p, e_w, e_u, e_nx, e_lg;
  logic [VPN_W-1:0]   e_tag [ENTRIES];
  logic [PTR_W-1:0]   fill_ptr;
  logic [ENTRIES-1:0] hit_vec;
  logic [PTR_W-1:0]   sel;
  logic               hit, is_write, is_fetch, violation, deny, do_fault;
  logic [4:0]         code_n;
  logic               unused_pte_bits;

  assign unused_pte_bits = ^{fill_pte[62:8], fill_pte[6:3]};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign hit_vec[g] = e_valid[g]
      && (req_vpn[VPN_W-1:LARGE_BITS] == e_tag[g][VPN_W-1:LARGE_BITS])
      && (e_lg[g] || (req_vpn[LARGE_BITS-1:0] == e_tag[g][LARGE_BITS-1:0]));
  end

  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_vec[i]) sel = PTR_W'(i);
  end

  assign hit       = |hit_vec;
  assign is_write  = (req_type == ACC_WRITE);
  assign is_fetch  = (req_type == ACC_FETCH);
  assign violation = (is_write && !e_w[sel])
                   || (req_user && !e_u[sel])
                   || (is_fetch && nx_enable && e_nx[sel]);
  assign deny      = !e_p[sel] || violation;
  assign do_fault  = req_valid && hit && deny;
  assign code_n    = {is_fetch, 1'b0, req_user, is_write, e_p[sel]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant      <= 1'b0;
      fault      <= 1'b0;
      miss       <= 1'b0;
      fault_code <= '0;
    end else begin
      grant      <= req_valid && hit && !deny;
      fault      <= do_fault;
      miss       <= req_valid && !hit;
      fault_code <= do_fault ? code_n : 5'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_valid  <= '0;
      fill_ptr <= '0;
    end else if (flush) begin
      e_valid  <= '0;
      fill_ptr <= '0;
    end else if (fill_valid) begin
      e_valid[fill_ptr] <= 1'b1;
      fill_ptr <= (fill_ptr == PTR_W'(ENTRIES - 1)) ? '0 : fill_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_valid && !flush) begin
      e_tag[fill_ptr] <= fill_vpn;
      e_p[fill_ptr]   <= fill_pte[BIT_P];
      e_w[fill_ptr]   <= fill_pte[BIT_W];
      e_u[fill_ptr]   <= fill_pte[BIT_U];
      e_lg[fill_ptr]  <= fill_pte[BIT_LG];
      e_nx[fill_ptr]  <= fill_pte[BIT_NX];
    end
  end
endmodule

// File: rtl/ifetch_perm_check_sva.sv
module ifetch_perm_check_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       flush,
  input logic       req_valid,
  input logic [1:0] req_type,
  input logic       req_user,
  input logic       grant,
  input logic       fault,
  input logic       miss,
  input logic [4:0] fault_code
);
  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant, fault, miss}));

  assert_answer_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (grant || fault || miss));

  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(grant || fault || miss));

  assert_flush_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush ##1 req_valid |=> miss);

  assert_fetch_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!fault || (fault_code[4] == ($past(req_type) == 2'b10))));

  assert_user_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!fault || (fault_code[2] == $past(req_user))));

  assert_idle_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> (fault_code == 5'd0));

  assert_bit3_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_code[3]);
endmodule

bind ifetch_perm_check ifetch_perm_check_sva u_sva (
  .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid),
  .req_type(req_type), .req_user(req_user), .grant(grant), .fault(fault),
  .miss(miss), .fault_code(fault_code)
);

// File: tb/tb_ifetch_perm_check.sv
module tb_ifetch_perm_check;
  localparam time CLK_PERIOD = 10ns;
  localparam int  VW = 20;
  localparam int  NE = 8;
  localparam int  WATCHDOG = 100000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 0, fill_valid = 0, req_valid = 0, req_user = 0, nx_enable = 0;
  logic [VW-1:0] fill_vpn = '0, req_vpn = '0;
  logic [63:0] fill_pte = '0;
  logic [1:0] req_type = '0;
  logic grant, fault, miss;
  logic [4:0] fault_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifetch_perm_check dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fill_valid(fill_valid),
    .fill_vpn(fill_vpn), .fill_pte(fill_pte), .req_valid(req_valid),
    .req_type(req_type), .req_vpn(req_vpn), .req_user(req_user),
    .nx_enable(nx_enable), .grant(grant), .fault(fault), .miss(miss),
    .fault_code(fault_code)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  logic          m_valid [NE];
  logic [VW-1:0] m_tag [NE];
  logic [63:0]   m_pte [NE];
  int            m_ptr = 0;
  logic xg, xf, xm;
  logic [4:0] xc;
  string xtag;

  function automatic logic [63:0] mk(bit p, bit w, bit u, bit nx, bit lg);
    logic [63:0] r = '0;
    r[0] = p; r[1] = w; r[2] = u; r[7] = lg; r[63] = nx;
    return r;
  endfunction

  task automatic model_expect(logic rv, logic [1:0] rt, logic [VW-1:0] v, logic usr, logic nxe);
    int idx = -1;
    xg = 0; xf = 0; xm = 0; xc = 0; xtag = "R5";
    if (!rv) return;
    for (int i = NE - 1; i >= 0; i--)
      if (m_valid[i] && m_tag[i][VW-1:9] == v[VW-1:9] &&
          (m_pte[i][7] || m_tag[i][8:0] == v[8:0])) idx = i;
    if (idx < 0) begin xm = 1; xtag = "R2"; return; end
    begin
      logic [63:0] e = m_pte[idx];
      bit wr = (rt == 2'b01), fe = (rt == 2'b10);
      bit bad = !e[0] || (wr && !e[1]) || (usr && !e[2]) || (fe && nxe && e[63]);
      if (bad) begin
        xf = 1; xc = {fe, 1'b0, usr, wr, e[0]};
        xtag = !e[0] ? "R6" : (fe && nxe && e[63]) ? "R7" : "R10";
      end else begin
        xg = 1; xtag = (fe && !nxe && e[63]) ? "R8" : (e[63] ? "R9" : "R11");
      end
    end
  endtask

  task automatic step(logic fl, logic fv, logic [VW-1:0] fvpn, logic [63:0] fpte,
                      logic rv, logic [1:0] rt, logic [VW-1:0] rvpn, logic usr, logic nxe);
    flush = fl; fill_valid = fv; fill_vpn = fvpn; fill_pte = fpte;
    req_valid = rv; req_type = rt; req_vpn = rvpn; req_user = usr; nx_enable = nxe;
    model_expect(rv, rt, rvpn, usr, nxe);
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < NE; i++) m_valid[i] = 0;
      m_ptr = 0;
    end else if (fv) begin
      m_valid[m_ptr] = 1; m_tag[m_ptr] = fvpn; m_pte[m_ptr] = fpte;
      m_ptr = (m_ptr + 1) % NE;
    end
    @(negedge clk);
    flush = 0; fill_valid = 0; req_valid = 0;
  endtask

  task automatic check(string tag, logic g, logic f, logic m, logic [4:0] c);
    checks++;
    if (grant !== g || fault !== f || miss !== m || fault_code !== c) begin
      fails++;
      $display("FAIL %s: got g=%0b f=%0b m=%0b code=%02h, expected g=%0b f=%0b m=%0b code=%02h",
               tag, grant, fault, miss, fault_code, g, f, m, c);
    end
  endtask

  task automatic fill(logic [VW-1:0] v, logic [63:0] p);
    step(0, 1, v, p, 0, 0, 0, 0, 0);
  endtask

  task automatic req(logic [1:0] t, logic [VW-1:0] v, logic u, logic n);
    step(0, 0, 0, 0, 1, t, v, u, n);
  endtask

  task automatic do_flush();
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: got cycle %0d, expected under %0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < NE; i++) begin m_valid[i] = 0; m_tag[i] = '0; m_pte[i] = '0; end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset outputs", 0, 0, 0, 5'h00);
    req(2'b00, 20'h5, 0, 0);
    check("R1 empty after reset", 0, 0, 1, 5'h00);

    fill(20'h10, mk(1, 1, 1, 1, 0));
    req(2'b10, 20'h10, 0, 1); check("R7 supervisor fetch of nx page", 0, 1, 0, 5'h11);
    req(2'b10, 20'h10, 0, 0); check("R8 nx ignored when disabled", 1, 0, 0, 5'h00);
    req(2'b00, 20'h10, 1, 1); check("R9 read of nx page", 1, 0, 0, 5'h00);
    req(2'b01, 20'h10, 0, 1); check("R9 write of nx page", 1, 0, 0, 5'h00);
    req(2'b11, 20'h10, 0, 1); check("R9 type 11 treated as read", 1, 0, 0, 5'h00);
    req(2'b10, 20'h10, 1, 1); check("R10 user fetch of nx page", 0, 1, 0, 5'h15);
    req(2'b00, 20'h11, 0, 1); check("R2 neighbour page misses", 0, 0, 1, 5'h00);

    fill(20'h20, mk(0, 1, 1, 0, 0));
    req(2'b00, 20'h20, 0, 1); check("R6 not present read", 0, 1, 0, 5'h00);
    req(2'b01, 20'h20, 1, 1); check("R6 R11 not present user write", 0, 1, 0, 5'h06);

    fill(20'h30, mk(1, 0, 0, 0, 0));
    req(2'b01, 20'h30, 0, 1); check("R10 R11 write to read-only", 0, 1, 0, 5'h03);
    req(2'b00, 20'h30, 1, 1); check("R10 user read of supervisor page", 0, 1, 0, 5'h05);
    req(2'b10, 20'h30, 0, 1); check("R11 supervisor fetch granted", 1, 0, 0, 5'h00);

    fill(20'h200, mk(1, 1, 1, 1, 1));
    req(2'b10, 20'h2AB, 0, 1); check("R12 large page nx fetch", 0, 1, 0, 5'h11);
    req(2'b00, 20'h3FF, 0, 1); check("R12 large page read top", 1, 0, 0, 5'h00);
    req(2'b00, 20'h400, 0, 1); check("R12 beyond large page", 0, 0, 1, 5'h00);

    do_flush();
    req(2'b00, 20'h10, 0, 0); check("R4 flush clears", 0, 0, 1, 5'h00);
    for (int i = 1; i <= 9; i++) fill(VW'(i), mk(1, 1, 1, 0, 0));
    req(2'b00, 20'h1, 0, 0); check("R3 oldest evicted", 0, 0, 1, 5'h00);
    req(2'b00, 20'h2, 0, 0); check("R3 second kept", 1, 0, 0, 5'h00);
    req(2'b00, 20'h9, 0, 0); check("R3 wrapped fill present", 1, 0, 0, 5'h00);

    step(1, 1, 20'h55, mk(1, 1, 1, 0, 0), 0, 0, 0, 0, 0);
    req(2'b00, 20'h55, 0, 0); check("R4 fill dropped on flush", 0, 0, 1, 5'h00);
    fill(20'h60, mk(1, 1, 1, 0, 0));
    for (int i = 0; i < NE - 1; i++) fill(VW'(20'h70 + i), mk(1, 1, 1, 0, 0));
    req(2'b00, 20'h60, 0, 0); check("R4 pointer at 0, first entry kept", 1, 0, 0, 5'h00);
    fill(20'h80, mk(1, 1, 1, 0, 0));
    req(2'b00, 20'h60, 0, 0); check("R4 pointer restart then evict", 0, 0, 1, 5'h00);

    do_flush();
    step(0, 1, 20'h90, mk(1, 1, 1, 0, 0), 1, 2'b00, 20'h90, 0, 0);
    check("R13 lookup sees pre-fill state", 0, 0, 1, 5'h00);
    fill(20'h90, mk(0, 0, 0, 0, 0));
    req(2'b00, 20'h90, 0, 0); check("R13 lowest index wins", 1, 0, 0, 5'h00);
    step(1, 0, 0, 0, 1, 2'b00, 20'h90, 0, 0);
    check("R13 lookup during flush hits", 1, 0, 0, 5'h00);

    for (int n = 0; n < 3000; n++) begin
      int op = $urandom_range(0, 19);
      logic [VW-1:0] v = VW'(($urandom_range(0, 3) << 9) | $urandom_range(0, 3));
      logic [VW-1:0] fv = VW'(($urandom_range(0, 3) << 9) | $urandom_range(0, 3));
      logic [63:0] p = mk($urandom_range(0, 5) != 0, $urandom_range(0, 1), $urandom_range(0, 1),
                          $urandom_range(0, 1), $urandom_range(0, 3) == 0);
      logic rv = (op >= 4);
      logic [1:0] rt = 2'($urandom_range(0, 3));
      step(op == 0, (op >= 1 && op <= 5), fv, p, rv, rt, v,
           $urandom_range(0, 1), $urandom_range(0, 3) != 0);
      check({xtag, " random"}, xg, xf, xm, xc);
    end
    finish_run();
  end
endmodule